// File: doc/BRIEF.md
# Descriptor Chain Walker for Scatter-Gather DMA

This block follows a linked list of 16-byte transfer descriptors held in memory. The channel controller starts it with a pointer to the first descriptor and with the direction the whole command should move data. The walker reads each descriptor as four 32-bit little-endian words over a simple read port, then checks it. It issues one burst request to the data mover for each valid descriptor. After the burst is acknowledged, it follows the descriptor's next pointer.

The walk ends in one of two ways. It raises a one-cycle done pulse after the burst of a descriptor marked as last. It raises a one-cycle error pulse, with a cause code, when it meets a descriptor it refuses. Each descriptor word has a fixed role:

- Word 0 is the buffer address.
- Word 1 is a length counted in 8-byte units.
- Word 2 holds a flags byte in bits 7:0, a timing-mode byte in bits 15:8, a packet-length byte and a spare byte.
- Word 3 is the next-descriptor address.

The walker moves no data itself. It passes the timing mode through unchanged.

Top module: `prd_walker`

## Requirements
- R1: After reset, and whenever it is not busy, the walker drives `busy`, `mem_req`, `burst_req`, `done` and `err` low.
- R2: For each descriptor, the walker reads four consecutive 32-bit words in order, starting at the descriptor address with its low 3 bits cleared. Each read is a one-cycle `mem_req`, and the next read waits for the `mem_rvalid` of the previous one.
- R3: A burst carries these fields from the descriptor:
  - `burst_addr` is word 0.
  - `burst_bytes` is word 1 times 8.
  - `burst_to_dev` is flags bit 5 (word 2 bit 5).
  - `burst_mode` is the low 4 bits of the timing-mode byte (word 2 bits 11:8). The upper bits of that byte are ignored.
- R4: The walker issues exactly one burst per accepted descriptor. It holds `burst_req` and the burst fields steady until `burst_ack`, and it makes no memory read while a burst is pending.
- R5: A descriptor with flags bit 7 set is the last one. The cycle after its burst is acknowledged, `done` pulses, and its next pointer is ignored.
- R6: On a descriptor without flags bit 7, once its burst is acknowledged, the walk continues at word 3 with its low 3 bits cleared.
- R7: A length word of zero ends the walk with `err` and `err_code` = 1, and no burst is issued for that descriptor.
- R8: If flags bit 5 differs from the `to_dev` intent latched at start, the walk ends with `err` and `err_code` = 2, and no burst is issued for that descriptor.
- R9: If a descriptor without flags bit 7 has a next pointer that is zero once its low 3 bits are cleared, the walk ends with `err` and `err_code` = 3, and no burst is issued for it. When several faults are present, cause 1 outranks 2, and 2 outranks 3.
- R10: A `start` raised while the walker is busy is ignored. The running walk keeps its pointer and direction.
- R11: `done` and `err` are single-cycle pulses, never high together, and they coincide with `busy` going low. `err_code` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| start_ptr | input | AW | Address of the first descriptor |
| to_dev | input | 1 | Direction intent of the command: 1 = toward device |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| burst_req | output | 1 | Burst request, held until acknowledged |
| burst_addr | output | AW | Buffer address of the burst |
| burst_bytes | output | LENW+3 | Byte count of the burst |
| burst_to_dev | output | 1 | Burst direction |
| burst_mode | output | MODEW | Timing mode passed through |
| burst_ack | input | 1 | Data mover accepts the burst |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | Chain finished cleanly (pulse) |
| err | output | 1 | Walk aborted (pulse) |
| err_code | output | 2 | Cause: 1 zero length, 2 direction mismatch, 3 missing next pointer |

## Verification
The hardest situations to reach are the faults buried deep in a chain, and overlapping faults that test the priority order. Each needs a descriptor list laid out in memory so that earlier entries succeed and the faulty entry is reached only after several pointer hops.

The bench builds random chains of up to five descriptors in scattered memory slots. It sets random junk in the low pointer bits and in the upper nibble of the mode byte. At a random position it injects a zero length, a flipped direction bit or a cleared next pointer. A reference walk over the same memory image predicts the bursts, the number of reads and the ending.

// File: rtl/prd_walker.sv
module prd_walker #(
  parameter int AW    = 32,
  parameter int LENW  = 32,
  parameter int MODEW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_ptr,
  input  logic             to_dev,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             burst_req,
  output logic [AW-1:0]    burst_addr,
  output logic [LENW+2:0]  burst_bytes,
  output logic             burst_to_dev,
  output logic [MODEW-1:0] burst_mode,
  input  logic             burst_ack,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code
);
  localparam int LAST_BIT = 7;
  localparam int DIR_BIT  = 5;
  localparam int MODE_LSB = 8;
  localparam int WORDS    = 4;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_EVAL, S_BURST} state_t;

  state_t      st;
  logic [AW-1:0] ptr;
  logic [1:0]  widx;
  logic [31:0] w [WORDS];
  logic        intent;
  logic        done_q, err_q;
  logic [1:0]  code_q;

  wire len_zero  = w[1][LENW-1:0] == '0;
  wire dir_bad   = w[2][DIR_BIT] != intent;
  wire is_last   = w[2][LAST_BIT];
  wire next_zero = !is_last && (w[3][AW-1:3] == '0);

  assign mem_req      = st == S_FETCH;
  assign mem_addr     = ptr + AW'({widx, 2'b00});
  assign burst_req    = st == S_BURST;
  assign burst_addr   = w[0][AW-1:0];
  assign burst_bytes  = {w[1][LENW-1:0], 3'b000};
  assign burst_to_dev = w[2][DIR_BIT];
  assign burst_mode   = w[2][MODE_LSB +: MODEW];
  assign busy         = st != S_IDLE;
  assign done         = done_q;
  assign err          = err_q;
  assign err_code     = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ptr    <= '0;
      widx   <= '0;
      intent <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= 2'd0;
      for (int i = 0; i < WORDS; i++) w[i] <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ptr    <= {start_ptr[AW-1:3], 3'b000};
          intent <= to_dev;
          widx   <= '0;
          code_q <= 2'd0;
          st     <= S_FETCH;
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          w[widx] <= mem_rdata;
          if (widx == 2'(WORDS - 1)) st <= S_EVAL;
          else begin
            widx <= widx + 2'd1;
            st   <= S_FETCH;
          end
        end
        S_EVAL: begin
          if (len_zero || dir_bad || next_zero) begin
            err_q  <= 1'b1;
            code_q <= len_zero ? 2'd1 : dir_bad ? 2'd2 : 2'd3;
            st     <= S_IDLE;
          end else st <= S_BURST;
        end
        S_BURST: if (burst_ack) begin
          if (is_last) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            ptr  <= {w[3][AW-1:3], 3'b000};
            widx <= '0;
            st   <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prd_walker_chk.sv
module prd_walker_chk #(
  parameter int AW    = 32,
  parameter int LENW  = 32,
  parameter int MODEW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic             burst_req,
  input logic [AW-1:0]    burst_addr,
  input logic [LENW+2:0]  burst_bytes,
  input logic             burst_ack,
  input logic             busy,
  input logic             done,
  input logic             err
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !burst_req));
  a_r2_one_cycle_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r4_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_req && !burst_ack) |=> (burst_req && $stable(burst_addr) && $stable(burst_bytes)));
  a_r4_no_read_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> !mem_req);
  a_r7_nonzero_burst: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> burst_bytes != '0);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  a_r11_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);
endmodule

bind prd_walker prd_walker_chk #(.AW(AW), .LENW(LENW), .MODEW(MODEW)) u_chk (.*);

// File: tb/prd_walker_test.sv
`timescale 1ns/1ps
module prd_walker_test;
  logic        clk = 0, rst_n = 0, start = 0, to_dev = 0;
  logic [31:0] start_ptr = 0;
  logic        mem_req, mem_rvalid = 0, burst_req, burst_to_dev, burst_ack = 0;
  logic [31:0] mem_addr, mem_rdata = 0, burst_addr;
  logic [34:0] burst_bytes;
  logic [3:0]  burst_mode;
  logic        busy, done, err;
  logic [1:0]  err_code;

  always #4 clk = ~clk;

  prd_walker uut (.*);

  int checks = 0, errors = 0;
  logic [31:0] mem [64];
  int reads;
  logic [31:0] got_addr [16];
  logic [34:0] got_bytes [16];
  logic        got_dir [16];
  logic [3:0]  got_mode [16];
  int          got_n;
  logic [31:0] exp_addr [16];
  logic [34:0] exp_bytes [16];
  logic        exp_dir [16];
  logic [3:0]  exp_mode [16];
  int          exp_n, exp_reads, exp_code;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory read responder
  initial forever begin
    if (mem_req === 1'b1) begin
      logic [31:0] a;
      int d;
      a = mem_addr;
      reads++;
      d = $urandom % 3;
      @(negedge clk);
      repeat (d) @(negedge clk);
      mem_rdata = mem[a[7:2]];
      mem_rvalid = 1;
      @(negedge clk);
      mem_rvalid = 0;
    end else @(negedge clk);
  end

  // data mover responder
  initial forever begin
    if (burst_req === 1'b1) begin
      int d;
      if (got_n < 16) begin
        got_addr[got_n] = burst_addr; got_bytes[got_n] = burst_bytes;
        got_dir[got_n] = burst_to_dev; got_mode[got_n] = burst_mode;
      end
      got_n++;
      d = $urandom % 4;
      repeat (d) @(negedge clk);
      burst_ack = 1;
      @(negedge clk);
      burst_ack = 0;
    end else @(negedge clk);
  end

  // reference walk over the memory image
  task automatic model(input logic [31:0] sp, input bit intent);
    logic [31:0] p, w0, w1, w2, w3;
    p = sp & ~32'h7;
    exp_n = 0; exp_reads = 0; exp_code = 0;
    for (int k = 0; k < 16; k++) begin
      w0 = mem[p[7:2]]; w1 = mem[p[7:2] + 1]; w2 = mem[p[7:2] + 2]; w3 = mem[p[7:2] + 3];
      exp_reads += 4;
      if (w1 == 0) begin exp_code = 1; return; end
      if (w2[5] != intent) begin exp_code = 2; return; end
      if (!w2[7] && w3[31:3] == 0) begin exp_code = 3; return; end
      exp_addr[exp_n] = w0; exp_bytes[exp_n] = {w1, 3'b000};
      exp_dir[exp_n] = w2[5]; exp_mode[exp_n] = w2[11:8];
      exp_n++;
      if (w2[7]) return;
      p = w3 & ~32'h7;
    end
  endtask

  // build a chain of n descriptors; inject: 0 none, 1 zero length, 2 dir flip, 3 lost next
  task automatic build(input int n, input bit intent, input int inject, output logic [31:0] sp);
    int slots [15];
    int bad;
    for (int i = 0; i < 15; i++) slots[i] = i + 1;
    for (int i = 14; i > 0; i--) begin
      int j, t;
      j = $urandom % (i + 1); t = slots[i]; slots[i] = slots[j]; slots[j] = t;
    end
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    bad = $urandom % n;
    for (int i = 0; i < n; i++) begin
      int b;
      logic last, dir;
      b = slots[i] * 4;
      last = (i == n - 1);
      dir = intent;
      if (inject == 2 && i == bad) dir = ~dir;
      mem[b]     = $urandom;
      mem[b + 1] = (inject == 1 && i == bad) ? 32'd0 : 32'd1 + ($urandom % 2000);
      mem[b + 2] = {16'($urandom), 4'($urandom), 4'($urandom), last, 1'b0, dir, 1'b1, 4'($urandom)};
      if (inject == 3 && i == bad) begin
        mem[b + 2][7] = 1'b0;
        mem[b + 3] = $urandom % 8;
      end else if (last) mem[b + 3] = $urandom;
      else mem[b + 3] = slots[i + 1] * 16 + ($urandom % 8);
    end
    sp = slots[0] * 16 + ($urandom % 8);
  endtask

  task automatic run(input logic [31:0] sp, input bit intent, input bit poke, input string tag);
    int cnt, code;
    model(sp, intent);
    got_n = 0; reads = 0;
    @(negedge clk);
    start_ptr = sp; to_dev = intent; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_ptr = 32'h10; to_dev = ~intent; start = 1;   // R10 ignored while busy
      @(negedge clk);
      start = 0;
    end
    cnt = 0;
    while (!(done || err) && cnt < 3000) begin @(negedge clk); cnt++; end
    if (cnt >= 3000) begin
      check(0, {tag, " watchdog"}, cnt, 0);
      return;
    end
    code = err ? int'(err_code) : 0;
    check(code == exp_code, {tag, " ending R5 R7 R8 R9"}, code, exp_code);
    check(!busy, {tag, " R11 busy low at end"}, busy, 0);
    check(got_n == exp_n, {tag, " R4 burst count"}, got_n, exp_n);
    check(reads == exp_reads, {tag, " R2 R6 read count"}, reads, exp_reads);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      check(got_addr[i] == exp_addr[i], {tag, " R3 addr"}, got_addr[i], exp_addr[i]);
      check(got_bytes[i] == exp_bytes[i], {tag, " R3 bytes"}, got_bytes[i], exp_bytes[i]);
      check(got_dir[i] == exp_dir[i], {tag, " R3 dir"}, got_dir[i], exp_dir[i]);
      check(got_mode[i] == exp_mode[i], {tag, " R3 mode"}, got_mode[i], exp_mode[i]);
    end
    @(negedge clk);
    check(!done && !err, {tag, " R11 single pulse"}, {done, err}, 0);
    check(!mem_req && !burst_req, {tag, " R1 quiet after end"}, {mem_req, burst_req}, 0);
    if (exp_code != 0)
      check(err_code == 2'(exp_code), {tag, " R11 code held"}, err_code, exp_code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "global watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] sp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !mem_req && !burst_req && !done && !err, "R1 reset state",
          {busy, mem_req, burst_req, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !mem_req && !burst_req, "R1 idle after reset", {busy, mem_req, burst_req}, 0);

    build(1, 0, 0, sp); run(sp, 0, 0, "single R5");
    build(3, 1, 0, sp); run(sp, 1, 0, "chain R6");
    build(4, 1, 1, sp); run(sp, 1, 0, "zero-len R7");
    build(3, 0, 2, sp); run(sp, 0, 0, "dir R8");
    build(3, 1, 3, sp); run(sp, 1, 0, "no-next R9");
    // priority: zero length and direction flip on the same entry -> code 1
    build(2, 0, 0, sp);
    mem[(sp[7:4]) * 4 + 1] = 0; mem[(sp[7:4]) * 4 + 2][5] = 1'b1;
    run(sp, 0, 0, "prio R9");
    build(5, 0, 0, sp); run(sp, 0, 1, "busy-start R10");

    for (int t = 0; t < 40; t++) begin
      int inj;
      bit dir;
      inj = ($urandom % 3 == 0) ? 1 + ($urandom % 3) : 0;
      dir = $urandom % 2;
      build(1 + ($urandom % 5), dir, inj, sp);
      run(sp, dir, ($urandom % 5) == 0, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule